// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block takes one input clock and produces two identical output clocks. A 3-bit ratio select chooses the output: the input clock passed straight through, or the input divided by 2, 4, 8 or 16. The divided outputs have a 50% duty cycle.

An active-low run input starts and stops the block. Its level is captured only on a falling edge of the input clock. A two-state gate machine holds that captured level. The machine has the states `GATE_HALT` and `GATE_RUN`. The transition `halt_to_run` is taken when run is seen high at a falling edge. The transition `run_to_halt` is taken when run is seen low at a falling edge. Each state otherwise stays where it is.

While the machine is in `GATE_HALT`:
- the divider counter is cleared on every rising edge;
- both outputs are held low.

When the machine enters `GATE_RUN`, every divided mode starts from the same phase. Its first output rising edge falls on the first input rising edge after the capturing falling edge. The pass-through output is gated by the same falling-edge state, so it never emits a partial high pulse.

Top module: `pow2_clk_divider`

## Requirements
- R1: With `ratio_sel` = 3'b000, while running, each output equals `clk_in`.
- R2: With `ratio_sel` = 3'b001, 3'b010 or 3'b011, while running, each output has a period of 2, 4 or 8 input cycles and a 50% duty cycle. Its edges coincide with rising edges of `clk_in`.
- R3: Any `ratio_sel` with bit 2 set gives division by 16. This includes 3'b111, which is the tie-high value an undriven select takes.
- R4: `run_n` is sampled only on the falling edge of `clk_in`. A change takes effect at that edge. A low pulse that does not span a falling edge has no effect on the outputs.
- R5: While halted in a divided mode, both outputs are 0 and the divider counter is cleared.
- R6: After a release, a divided output first goes high at the first rising edge of `clk_in` that follows the capturing falling edge. It then repeats its normal pattern.
- R7: Both output channels are identical at all times.
- R8: In pass-through mode the output is forced low from the capturing falling edge onward, so neither a halt nor a release produces a shortened high pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be passed through or divided |
| run_n | input | 1 | Active-low halt; high lets the divider run (captured on falling edge) |
| ratio_sel | input | 3 | Ratio select: 000 /1, 001 /2, 010 /4, 011 /8, 1xx /16 |
| clk_out | output | 2 | Two identical output clocks |

## Verification
A halt and an output edge can fall in the same input cycle. The bench lowers `run_n` while `clk_in` is high, often while a divided output is high or about to toggle. The falling-edge capture then has to cut that output low halfway through the cycle, before the counter clears on the next rising edge.

A behavioural model tracks the captured run level and the number of rising edges since release. From these it computes the expected output level for every select. Both outputs are compared against the model in the high half and in the low half of every input cycle. This checks that the halt lands on the falling edge and not on the rising edge around it.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;

    // Captured state of the active-low run input.
    typedef enum logic {
        GATE_HALT = 1'b0,
        GATE_RUN  = 1'b1
    } gate_state_t;

endpackage

// File: rtl/pow2div_gate.sv
module pow2div_gate
    import pow2div_pkg::*;
(
    input  logic clk_in,
    input  logic run_n,
    output logic run_en
);

    gate_state_t state_q;
    gate_state_t state_d;

    // Next-state logic: halt_to_run / run_to_halt follow the run level.
    always_comb begin
        unique case (state_q)
            GATE_HALT: state_d = run_n ? GATE_RUN : GATE_HALT;
            GATE_RUN:  state_d = run_n ? GATE_RUN : GATE_HALT;
            default:   state_d = GATE_HALT;
        endcase
    end

    // The state register updates only on the falling edge of the input clock.
    always_ff @(negedge clk_in) begin
        state_q <= state_d;
    end

    always_comb begin
        run_en = (state_q == GATE_RUN);
    end

    // R4: a high run level seen at one falling edge means running at the next.
    assert_sync_on_fall_R4: assert property (
        @(negedge clk_in) disable iff (!run_n)
        $past(run_n) |-> state_q == GATE_RUN
    );

endmodule

// File: rtl/pow2div_count.sv
module pow2div_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk_in,
    input  logic             run_n,
    input  logic             run_en,
    output logic [CNT_W-1:0] cnt
);

    // Down counter: leaving zero sets every bit high, so all ratios rise together.
    always_ff @(posedge clk_in) begin
        if (!run_en) begin
            cnt <= '0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R2: while running, the count steps down by one per rising edge.
    assert_count_step_R2: assert property (
        @(posedge clk_in) disable iff (!run_n || !run_en)
        $past(run_en) |-> cnt == CNT_W'($past(cnt) - 1'b1)
    );

    // R6: the first rising edge after a release starts from a cleared count.
    assert_release_phase_R6: assert property (
        @(posedge clk_in) disable iff (!run_n)
        (run_en && !$past(run_en)) |-> cnt == '0
    );

endmodule

// File: rtl/pow2div_mux.sv
module pow2div_mux #(
    parameter int CNT_W = 4,
    parameter int SEL_W = 3,
    parameter int N_OUT = 2
) (
    input  logic             clk_in,
    input  logic             run_n,
    input  logic             run_en,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic [CNT_W-1:0] cnt,
    output logic [N_OUT-1:0] clk_out
);

    localparam int TAP_N = CNT_W + 1;
    localparam int IDX_W = $clog2(TAP_N);

    logic [TAP_N-1:0] taps;
    logic [IDX_W-1:0] idx;
    logic             sel_clk;

    // Tap 0 is the bypass clock; tap n is counter bit n-1 (divide by 2^n).
    assign taps[0] = clk_in;
    for (genvar g = 1; g < TAP_N; g++) begin : g_tap
        assign taps[g] = cnt[g-1];
    end

    // Select decoder: values at or above CNT_W saturate to the deepest tap.
    always_comb begin
        if (ratio_sel >= SEL_W'(CNT_W)) begin
            idx = IDX_W'(CNT_W);
        end else begin
            idx = IDX_W'(ratio_sel);
        end
    end

    // Gating by the falling-edge state keeps the bypass clock free of runts.
    always_comb begin
        sel_clk = taps[idx] & run_en;
    end

    for (genvar ch = 0; ch < N_OUT; ch++) begin : g_chan
        assign clk_out[ch] = sel_clk;
    end

    // R5: while halted, no channel is high at a rising edge.
    assert_halt_low_R5: assert property (
        @(posedge clk_in) disable iff (!run_n)
        !run_en |-> clk_out == '0
    );

endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider #(
    parameter int CNT_W = 4,
    parameter int SEL_W = 3,
    parameter int N_OUT = 2
) (
    input  logic             clk_in,
    input  logic             run_n,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic [N_OUT-1:0] clk_out
);

    logic             run_en;
    logic [CNT_W-1:0] cnt;

    pow2div_gate u_gate (
        .clk_in (clk_in),
        .run_n  (run_n),
        .run_en (run_en)
    );

    pow2div_count #(.CNT_W(CNT_W)) u_count (
        .clk_in (clk_in),
        .run_n  (run_n),
        .run_en (run_en),
        .cnt    (cnt)
    );

    pow2div_mux #(.CNT_W(CNT_W), .SEL_W(SEL_W), .N_OUT(N_OUT)) u_mux (
        .clk_in    (clk_in),
        .run_n     (run_n),
        .run_en    (run_en),
        .ratio_sel (ratio_sel),
        .cnt       (cnt),
        .clk_out   (clk_out)
    );

    // R2: in divide-by-2 with a steady select, the output flips at every rising edge.
    assert_div2_toggle_R2: assert property (
        @(posedge clk_in) disable iff (!run_n || !run_en)
        ($past(run_en) && ratio_sel == SEL_W'(1) && $past(ratio_sel) == SEL_W'(1))
            |-> clk_out[0] != $past(clk_out[0])
    );

endmodule

// File: tb/sim_pow2_clk_divider.sv
module sim_pow2_clk_divider;

    logic       clk = 1'b0;
    logic       run_n = 1'b0;
    logic [2:0] sel = 3'b111;
    logic [1:0] out;

    int    checks = 0;
    int    errors = 0;
    int    k = -1;
    bit    m_en = 1'b0;
    bit    armed = 1'b0;
    string focus = "";

    always #5 clk = ~clk;

    pow2_clk_divider u0 (
        .clk_in    (clk),
        .run_n     (run_n),
        .ratio_sel (sel),
        .clk_out   (out)
    );

    // Reference model: captured run level and rising edges since release.
    always @(negedge clk) m_en <= run_n;
    always @(posedge clk) begin
        if (!m_en) k <= -1;
        else       k <= k + 1;
    end

    function automatic int ratio_bits(input logic [2:0] s);
        return s[2] ? 4 : int'(s[1:0]);
    endfunction

    function automatic logic expect_out();
        int n = ratio_bits(sel);
        if (!m_en) return 1'b0;
        if (n == 0) return clk;
        if (k < 0) return 1'b0;
        return ((k % 16) % (1 << n)) < (1 << (n - 1));
    endfunction

    function automatic string tag();
        int n = ratio_bits(sel);
        if (focus != "") return focus;
        if (!m_en) return (n == 0) ? "R8" : "R5";
        if (run_n !== m_en) return "R4";
        if (n == 0) return "R1";
        if (k < (1 << n)) return "R6";
        if (n == 4) return "R3";
        return "R2";
    endfunction

    task automatic compare();
        logic e;
        if (!armed) return;
        e = expect_out();
        checks++;
        if (out[0] !== e) begin
            errors++;
            $display("FAIL %s t=%0t sel=%b out0=%b expected %b", tag(), $time, sel, out[0], e);
        end
        checks++;
        if (out[1] !== out[0]) begin
            errors++;
            $display("FAIL R7 t=%0t out1=%b expected %b", $time, out[1], out[0]);
        end
    endtask

    always @(posedge clk) begin #3; compare(); end
    always @(negedge clk) begin #3; compare(); end

    task automatic restart(input logic [2:0] s, input int hold, input int run);
        @(posedge clk); #1;
        run_n = 1'b0;
        sel   = s;
        repeat (hold) @(posedge clk);
        #1 run_n = 1'b1;
        repeat (run) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        armed = 1'b1;                       // reset state: outputs low (R5)
        repeat (3) @(posedge clk);
        for (int s = 0; s < 8; s++) begin
            restart(3'(s), 3, 40);          // R1, R2, R3, R6 per select
        end
        restart(3'b000, 1, 6);              // R8: one-cycle halt in pass-through
        restart(3'b011, 1, 20);             // R5/R6: short halt in divide-by-8
        // R4: low pulse inside the high phase, never seen at a falling edge
        @(posedge clk); #1;
        focus = "R4";
        run_n = 1'b0;
        #1 run_n = 1'b1;
        repeat (3) @(posedge clk);
        focus = "";
        // Select changes while running (model follows the free-running phase)
        #1 sel = 3'b010;
        repeat (20) @(posedge clk);
        #1 sel = 3'b111;                    // R3: tie-high value
        repeat (40) @(posedge clk);
        restart(3'b001, 2, 10);
        restart(3'b100, 2, 40);
        finish_run();
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule